// File: doc/BRIEF.md
# Watchdog Timer with Enable Flag

This block guards a processor against runaway code. A free-running counter advances once per instruction clock. When the counter wraps for the first time, a first-stage flag is raised. If the counter wraps again before software has cleared that flag, the block requests a system reset. Software keeps the watchdog quiet by issuing a restart command often enough. Each restart that finds the first-stage flag raised clears the flag and tells the core to skip the next instruction.

A one-bit enable decides whether a second wrap actually produces the reset request. The enable comes up set after system reset and whenever RAM back-up mode is entered. Software can clear it only with a disable command followed, in the very next cycle, by a restart command. While the enable is clear, the second wrap only latches a second-stage flag.

The core decodes the instructions and feeds two one-cycle strobes into this block. It receives back a one-cycle reset request and a one-cycle skip indication.

Top module: `wdog_guard`

## Requirements
- R1: A CNT_W-bit counter starts at 0 after reset and adds 1 on every clock. It wraps from all-ones to 0, so it overflows once every 2^CNT_W cycles.
- R2: An overflow while the first-stage flag is clear sets that flag and produces no reset request.
- R3: An overflow while the first-stage flag is set and the enable is set drives wdt_reset_o high for exactly one cycle, in the cycle after that clock edge. Both flags are cleared on the same edge.
- R4: A restart strobe while the first-stage flag is set clears the flag and drives skip_o high for exactly one cycle, in the cycle after the strobe. The reset request is pushed back by a full extra overflow period.
- R5: A restart strobe while the first-stage flag is clear produces no skip. If an overflow lands on the same edge, the first-stage flag is still set.
- R6: A restart strobe on the same edge as an overflow, with the first-stage flag set, takes priority. The result is a skip and no reset request.
- R7: A disable strobe followed directly, on the next clock, by a restart strobe alone clears the enable. After that, overflows with the first-stage flag set only set the second-stage flag and never raise wdt_reset_o.
- R8: In each of these cases the enable stays set: an idle cycle between disable and restart, restart before disable, or both strobes in the same cycle.
- R9: ram_backup_i high on a clock edge sets the enable. This takes priority over a completing disable sequence.
- R10: While rst_ni is low, the counter and both flags are cleared, the enable is set, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| ram_backup_i | input | 1 | High on entry to RAM back-up mode; sets the enable |
| restart_i | input | 1 | One-cycle restart command strobe |
| disable_i | input | 1 | One-cycle disable command strobe |
| wdt_reset_o | output | 1 | One-cycle watchdog reset request |
| skip_o | output | 1 | One-cycle skip-next-instruction indication |

## Verification
The bench aims at the ordering of the disable sequence. A design that accepts a restart arriving one cycle late, or arriving before the disable, would turn the watchdog off by accident; it is caught because the expected reset request never appears. A restart placed on the exact overflow edge checks arbitration. A wrong priority would fire a reset or drop the skip. A restart placed on a wrap with the flag clear must still let the flag set. A RAM back-up entry must revive the reset request after the enable was cleared; a design that forgets this would stay silent for good. Every cycle outside the expected pulses is also watched, so a stretched pulse or a spurious skip is reported.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic restart;
    logic dis;
  } wdog_cmd_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = (cnt_q == CntMax);

  assert_wrap_to_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_enable.sv
module wdog_enable
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ram_backup_i,
  input  wdog_cmd_t cmd_i,
  output logic      wef_o
);
  logic armed_q;
  logic wef_q;
  logic seq_done;

  // sequence completes only on a lone restart right after a disable
  assign seq_done = armed_q & cmd_i.restart & ~cmd_i.dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      wef_q   <= 1'b1;
    end else begin
      armed_q <= cmd_i.dis & ~cmd_i.restart;
      if (ram_backup_i)  wef_q <= 1'b1;
      else if (seq_done) wef_q <= 1'b0;
    end
  end

  assign wef_o = wef_q;

  assert_clear_needs_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wef_q) |-> ($past(armed_q) && $past(cmd_i.restart)));
  assert_backup_sets_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_backup_i |=> wef_q);
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic restart_i,
  input  logic wef_i,
  output logic fire_o,
  output logic skip_o
);
  logic wdf1_q, wdf2_q;
  logic fire_q, skip_q;
  logic rs_hit;

  assign rs_hit = restart_i & wdf1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdf1_q <= 1'b0;
      wdf2_q <= 1'b0;
      fire_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= rs_hit;
      fire_q <= ovf_i & wdf1_q & ~restart_i & wef_i;
      if (rs_hit) begin
        wdf1_q <= 1'b0;
      end else if (ovf_i) begin
        if (!wdf1_q) begin
          wdf1_q <= 1'b1;
        end else if (wef_i) begin
          wdf1_q <= 1'b0;
          wdf2_q <= 1'b0;
        end else begin
          wdf2_q <= 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;
  assign skip_o = skip_q;

  assert_fire_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(wef_i));
  assert_fire_clears_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> (!wdf1_q && !wdf2_q));
  assert_skip_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> ($past(wdf1_q) && $past(restart_i)));
  assert_no_fire_on_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !fire_q);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ram_backup_i,
  input  logic restart_i,
  input  logic disable_i,
  output logic wdt_reset_o,
  output logic skip_o
);
  wdog_cmd_t cmd;
  logic      ovf;
  logic      wef;

  assign cmd.restart = restart_i;
  assign cmd.dis     = disable_i;

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ovf_o (ovf)
  );

  wdog_enable u_enable (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ram_backup_i(ram_backup_i),
    .cmd_i       (cmd),
    .wef_o       (wef)
  );

  wdog_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf),
    .restart_i(restart_i),
    .wef_i    (wef),
    .fire_o   (wdt_reset_o),
    .skip_o   (skip_o)
  );

  assert_reset_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_reset_o |=> !wdt_reset_o);
  assert_skip_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !skip_o);
  always_comb begin
    if (!rst_ni) assert_reset_idle_R10: assert (!wdt_reset_o && !skip_o);
  end
endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;
  localparam int CNT_W = 4;  // overflow every 16 cycles

  typedef struct {
    int    cyc;
    bit    rst;
    bit    skip;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ram_backup_i = 1'b0;
  logic restart_i = 1'b0;
  logic disable_i = 1'b0;
  logic wdt_reset_o, skip_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  wdog_guard #(.CNT_W(CNT_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ram_backup_i(ram_backup_i),
    .restart_i   (restart_i),
    .disable_i   (disable_i),
    .wdt_reset_o (wdt_reset_o),
    .skip_o      (skip_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wdt_reset_o !== e.rst || skip_o !== e.skip) begin
          errors++;
          $display("FAIL %s cyc %0d: rst=%0b skip=%0b expected rst=%0b skip=%0b",
                   e.req, cyc, wdt_reset_o, skip_o, e.rst, e.skip);
        end
      end else if (wdt_reset_o !== 1'b0 || skip_o !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R3/R4 cyc %0d: unexpected rst=%0b skip=%0b expected rst=0 skip=0",
                 cyc, wdt_reset_o, skip_o);
      end
    end
  end

  task automatic expect_at(input int c, input bit r, input bit s, input string req);
    exp_t e;
    e.cyc = c; e.rst = r; e.skip = s; e.req = req;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ram_backup_i = 1'b0; restart_i = 1'b0; disable_i = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    // R10: outputs idle while reset is held
    checks++;
    if (wdt_reset_o !== 1'b0 || skip_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 in reset: rst=%0b skip=%0b expected rst=0 skip=0", wdt_reset_o, skip_o);
    end
    #1 rst_ni = 1'b1;
  endtask

  // drive strobes so that they are sampled on clock edge e
  task automatic at_edge(input int e, input bit r, input bit d, input bit b);
    while (cyc != e - 1) @(negedge clk);
    restart_i = r; disable_i = d; ram_backup_i = b;
    @(negedge clk);
    restart_i = 1'b0; disable_i = 1'b0; ram_backup_i = 1'b0;
  endtask

  task automatic run_to(input int c, input string req);
    while (cyc < c) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected items not seen, expected 0", req, q.size());
    end
  endtask

  initial begin
    // reset state and free run
    do_reset();
    expect_at(1, 0, 0, "R10");
    expect_at(16, 0, 0, "R2");
    expect_at(32, 1, 0, "R3");
    expect_at(33, 0, 0, "R3");
    expect_at(64, 1, 0, "R1");
    run_to(66, "R1");

    // restart with flag clear, then with flag set
    do_reset();
    expect_at(5, 0, 0, "R5");
    expect_at(20, 0, 1, "R4");
    expect_at(21, 0, 0, "R4");
    expect_at(32, 0, 0, "R4");
    expect_at(48, 1, 0, "R4");
    at_edge(5, 1, 0, 0);
    at_edge(20, 1, 0, 0);
    run_to(50, "R4");

    // valid disable sequence, then RAM back-up re-enables
    do_reset();
    expect_at(4, 0, 0, "R7");
    expect_at(32, 0, 0, "R7");
    expect_at(64, 0, 0, "R7");
    expect_at(70, 0, 1, "R7");
    expect_at(80, 0, 0, "R9");
    expect_at(96, 1, 0, "R9");
    at_edge(3, 0, 1, 0);
    at_edge(4, 1, 0, 0);
    at_edge(70, 1, 0, 0);
    at_edge(72, 0, 0, 1);
    run_to(98, "R9");

    // idle cycle between disable and restart
    do_reset();
    expect_at(5, 0, 0, "R8");
    expect_at(32, 1, 0, "R8");
    at_edge(3, 0, 1, 0);
    at_edge(5, 1, 0, 0);
    run_to(34, "R8");

    // restart before disable
    do_reset();
    expect_at(32, 1, 0, "R8");
    at_edge(3, 1, 0, 0);
    at_edge(4, 0, 1, 0);
    run_to(34, "R8");

    // both strobes together
    do_reset();
    expect_at(32, 1, 0, "R8");
    at_edge(3, 1, 1, 0);
    run_to(34, "R8");

    // restart on the overflow edge with the flag set
    do_reset();
    expect_at(32, 0, 1, "R6");
    expect_at(64, 1, 0, "R6");
    at_edge(32, 1, 0, 0);
    run_to(66, "R6");

    // restart on the overflow edge with the flag clear
    do_reset();
    expect_at(16, 0, 0, "R5");
    expect_at(32, 1, 0, "R5");
    at_edge(16, 1, 0, 0);
    run_to(34, "R5");

    // RAM back-up wins over a completing sequence
    do_reset();
    expect_at(32, 1, 0, "R9");
    at_edge(3, 0, 1, 0);
    at_edge(4, 1, 0, 1);
    run_to(34, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: bench hung at cyc %0d, expected completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule